// File: doc/BRIEF.md
# Debug Halt Arbiter with Interrupt-Entry Deferral

This block decides when a small processor stops for a debugger and what state it records when it stops. A break can come from a comparator pulse or from a watch on the interrupt-enable flag rising. The block weighs that break against the processor's interrupt-entry sequence. When no interrupt is involved, the processor stops at the next instruction boundary and the recorded program counter is the next instruction. When an interrupt is pending or already being entered, the interrupt wins. The stop is then held back until the return-state push has finished, and the recorded program counter is the handler's entry address.

The processor side reports four things: instruction boundaries with the address of the next instruction, a pending interrupt, a strobe when stacking completes together with the vector address, and its live flags. The block answers with a level halt request, a captured address and a captured four-bit flag snapshot. A one-cycle resume pulse releases the halt. An acknowledge pulse tells the processor to restart at the captured address.

Top module: `dbg_halt_arbiter`

## Requirements
- R1: After reset, `halt` is 0, `cap_pc` is 0 and `cap_flags` is 0.
- R2: A break raised while no interrupt is pending and no entry is in progress halts at the first cycle, at or after the request, with `insn_boundary` high. `halt` and `cap_pc` (equal to `next_pc` of that cycle) appear one clock later.
- R3: A break raised in a cycle where `irq_pending` is high does not halt at the boundary that takes the interrupt. It halts in the cycle `stack_done` pulses, and `cap_pc` then equals `vector_pc` of that cycle.
- R4: A break raised while an interrupt entry is in progress is held until `stack_done`. An entry is in progress from the boundary that took the interrupt until `stack_done`. The capture then follows R3.
- R5: `cap_flags` is loaded on the same clock as `cap_pc` with `cpu_flags` of the deciding cycle. The bits are ordered E, I, C, Z from bit 3 to bit 0, so a halt deferred to the end of entry reports I as 0.
- R6: With `flag_brk_en` high, a 0-to-1 change of `cpu_flags` bit 2 (I) acts as a break request in the cycle where the bit reads 1.
- R7: `halt` stays high until a `resume` pulse. The clock after `resume`, `halt` is 0 and `resume_go` is 1 for one cycle, and `cap_pc` still holds the restart address.
- R8: While halted, `brk_req` and flag rises are ignored. They neither alter the captures nor cause a halt after resume.
- R9: `resume` while running has no effect: `resume_go` stays 0.
- R10: Interrupt entry with no break request never raises `halt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_boundary | input | 1 | Processor is between instructions this cycle |
| next_pc | input | PC_W | Address of the next instruction, valid with insn_boundary |
| irq_pending | input | 1 | An interrupt will be taken at the next boundary |
| stack_done | input | 1 | Strobe: interrupt return state fully pushed |
| vector_pc | input | PC_W | Handler entry address, valid with stack_done |
| cpu_flags | input | 4 | Live flags E, I, C, Z (bit 3 to bit 0) |
| brk_req | input | 1 | Break pulse from compare logic |
| flag_brk_en | input | 1 | Enable break on rising I flag |
| resume | input | 1 | One-cycle release pulse from the debugger |
| halt | output | 1 | Processor must stop |
| cap_pc | output | PC_W | Captured restart address |
| cap_flags | output | 4 | Captured flag snapshot |
| resume_go | output | 1 | One-cycle restart acknowledge |

## Verification
A break request and an interrupt taken at an instruction boundary can fall in the same cycle, and this collision is what the bench is built around. A behavioural processor stub takes one interrupt at a fixed boundary, and the bench sweeps the break pulse across every cycle from before the pending window to past the end of stacking, for stacking lengths of one to four cycles. The flag-watch break is also placed on the very boundary that takes the interrupt. For each placement the bench predicts the deciding cycle from the requirements alone. It then judges the halt edge, the captured address (next instruction or vector) and the flag snapshot, including the cleared I flag when the halt is deferred.

// File: rtl/dbg_arb_pkg.sv
package dbg_arb_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_ARMED  = 2'd1,
        ST_HALTED = 2'd2
    } arb_state_e;

    localparam int FLAGS_W = 4;
    localparam int FLG_E   = 3;
    localparam int FLG_I   = 2;
    localparam int FLG_C   = 1;
    localparam int FLG_Z   = 0;
endpackage

// File: rtl/dbg_brk_trigger.sv
module dbg_brk_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    input  logic brk_req,
    input  logic flag_brk_en,
    input  logic flag_i,
    output logic trig
);
    typedef struct packed {
        logic prev_i;
    } trig_reg_t;

    trig_reg_t r_d, r_q;
    logic      i_rise;

    always_comb begin
        r_d        = r_q;
        r_d.prev_i = flag_i;
        i_rise     = flag_i && !r_q.prev_i;
        trig       = running && (brk_req || (flag_brk_en && i_rise));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/dbg_entry_tracker.sv
module dbg_entry_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic insn_boundary,
    input  logic irq_pending,
    input  logic stack_done,
    output logic entry_hold
);
    typedef struct packed {
        logic active;
    } entry_reg_t;

    entry_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (stack_done)
            r_d.active = 1'b0;
        else if (insn_boundary && irq_pending)
            r_d.active = 1'b1;
        entry_hold = irq_pending || r_q.active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_arb_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig,
    input  logic               entry_hold,
    input  logic               stack_done,
    input  logic               insn_boundary,
    input  logic [PC_W-1:0]    next_pc,
    input  logic [PC_W-1:0]    vector_pc,
    input  logic [FLAGS_W-1:0] cpu_flags,
    input  logic               resume,
    output logic               running,
    output logic               halt,
    output logic [PC_W-1:0]    cap_pc,
    output logic [FLAGS_W-1:0] cap_flags,
    output logic               resume_go
);
    typedef struct packed {
        arb_state_e         state;
        logic [PC_W-1:0]    pc;
        logic [FLAGS_W-1:0] flags;
        logic               go;
    } ctrl_reg_t;

    ctrl_reg_t r_d, r_q;
    logic      want;

    always_comb begin
        r_d    = r_q;
        r_d.go = 1'b0;
        want   = (r_q.state == ST_ARMED) || trig;
        case (r_q.state)
            ST_RUN, ST_ARMED: begin
                if (want) begin
                    if (stack_done) begin
                        r_d.state = ST_HALTED;
                        r_d.pc    = vector_pc;
                        r_d.flags = cpu_flags;
                    end else if (entry_hold) begin
                        r_d.state = ST_ARMED;
                    end else if (insn_boundary) begin
                        r_d.state = ST_HALTED;
                        r_d.pc    = next_pc;
                        r_d.flags = cpu_flags;
                    end else begin
                        r_d.state = ST_ARMED;
                    end
                end
            end
            ST_HALTED: begin
                if (resume) begin
                    r_d.state = ST_RUN;
                    r_d.go    = 1'b1;
                end
            end
            default: r_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_RUN, pc: '0, flags: '0, go: 1'b0};
        else        r_q <= r_d;
    end

    assign running   = (r_q.state != ST_HALTED);
    assign halt      = (r_q.state == ST_HALTED);
    assign cap_pc    = r_q.pc;
    assign cap_flags = r_q.flags;
    assign resume_go = r_q.go;
endmodule

// File: rtl/dbg_halt_arbiter.sv
module dbg_halt_arbiter
    import dbg_arb_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               insn_boundary,
    input  logic [PC_W-1:0]    next_pc,
    input  logic               irq_pending,
    input  logic               stack_done,
    input  logic [PC_W-1:0]    vector_pc,
    input  logic [FLAGS_W-1:0] cpu_flags,
    input  logic               brk_req,
    input  logic               flag_brk_en,
    input  logic               resume,
    output logic               halt,
    output logic [PC_W-1:0]    cap_pc,
    output logic [FLAGS_W-1:0] cap_flags,
    output logic               resume_go
);
    logic running;
    logic trig;
    logic entry_hold;

    dbg_brk_trigger trig_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .running     (running),
        .brk_req     (brk_req),
        .flag_brk_en (flag_brk_en),
        .flag_i      (cpu_flags[FLG_I]),
        .trig        (trig)
    );

    dbg_entry_tracker entry_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .insn_boundary (insn_boundary),
        .irq_pending   (irq_pending),
        .stack_done    (stack_done),
        .entry_hold    (entry_hold)
    );

    dbg_halt_ctrl #(.PC_W(PC_W)) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .trig          (trig),
        .entry_hold    (entry_hold),
        .stack_done    (stack_done),
        .insn_boundary (insn_boundary),
        .next_pc       (next_pc),
        .vector_pc     (vector_pc),
        .cpu_flags     (cpu_flags),
        .resume        (resume),
        .running       (running),
        .halt          (halt),
        .cap_pc        (cap_pc),
        .cap_flags     (cap_flags),
        .resume_go     (resume_go)
    );
endmodule

// File: rtl/dbg_halt_arbiter_chk.sv
module dbg_halt_arbiter_chk #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            insn_boundary,
    input logic [PC_W-1:0] next_pc,
    input logic            stack_done,
    input logic [PC_W-1:0] vector_pc,
    input logic            brk_req,
    input logic            resume,
    input logic            entry_hold,
    input logic            halt,
    input logic [PC_W-1:0] cap_pc,
    input logic            resume_go
);
    a_r2_boundary_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && brk_req && insn_boundary && !entry_hold && !stack_done)
        |=> (halt && cap_pc == $past(next_pc)));

    a_r3_stack_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && brk_req && stack_done)
        |=> (halt && cap_pc == $past(vector_pc)));

    a_r4_hold_during_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && entry_hold && !stack_done) |=> !halt);

    a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !resume) |=> halt);

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && resume) |=> (!halt && resume_go));

    a_r8_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(cap_pc));

    a_r9_no_spurious_go: assert property (@(posedge clk) disable iff (!rst_n)
        !halt |=> !resume_go);
endmodule

bind dbg_halt_arbiter dbg_halt_arbiter_chk #(.PC_W(PC_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_boundary (insn_boundary),
    .next_pc       (next_pc),
    .stack_done    (stack_done),
    .vector_pc     (vector_pc),
    .brk_req       (brk_req),
    .resume        (resume),
    .entry_hold    (entry_hold),
    .halt          (halt),
    .cap_pc        (cap_pc),
    .resume_go     (resume_go)
);

// File: tb/dbg_halt_arbiter_tb_top.sv
`timescale 1ns/1ps
module dbg_halt_arbiter_tb_top;
    localparam int PC_W = 16;
    localparam int BI   = 6;          // boundary that takes the interrupt
    localparam logic [PC_W-1:0] VEC = 16'h0800;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            insn_boundary = 1'b0;
    logic [PC_W-1:0] next_pc = '0;
    logic            irq_pending = 1'b0;
    logic            stack_done = 1'b0;
    logic [PC_W-1:0] vector_pc = VEC;
    logic [3:0]      cpu_flags = '0;
    logic            brk_req = 1'b0;
    logic            flag_brk_en = 1'b0;
    logic            resume = 1'b0;
    logic            halt;
    logic [PC_W-1:0] cap_pc;
    logic [3:0]      cap_flags;
    logic            resume_go;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dbg_halt_arbiter #(.PC_W(PC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .next_pc(next_pc),
        .irq_pending(irq_pending), .stack_done(stack_done), .vector_pc(vector_pc),
        .cpu_flags(cpu_flags), .brk_req(brk_req), .flag_brk_en(flag_brk_en),
        .resume(resume), .halt(halt), .cap_pc(cap_pc), .cap_flags(cap_flags),
        .resume_go(resume_go)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // stub model of the processor side
    function automatic bit bnd(int k, int len);
        return (k < BI && k % 2 == 0) || k == BI ||
               (k > BI + len && (k - BI - len) % 2 == 0);
    endfunction

    function automatic bit irqp(int k);
        return k == BI - 1 || k == BI;
    endfunction

    function automatic logic [3:0] flg(int k, int len, int tf);
        logic [3:0] kk;
        kk = k[3:0];
        if (tf >= 0)
            return {1'b0, (k >= tf) && (k <= BI || k > BI + len), 2'b00};
        if (k < BI)        return ~kk;
        if (k <= BI + len) return 4'b0000;   // entry clears the flags
        return kk;
    endfunction

    // deciding cycle derived from R2, R3, R4, R6
    function automatic int decide(int tb, int tf, int len);
        int t;
        t = tb;
        if (tf >= 0 && (t < 0 || tf < t)) t = tf;
        if (t < 0) return -1;
        for (int k = t; k < t + 40; k++) begin
            if (k == BI + len) return k;
            if (irqp(k) || (k >= BI && k < BI + len)) continue;
            if (bnd(k, len)) return k;
        end
        return -1;
    endfunction

    task automatic zero_inputs();
        insn_boundary = 1'b0; irq_pending = 1'b0; stack_done = 1'b0;
        brk_req = 1'b0; resume = 1'b0; cpu_flags = '0; next_pc = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        zero_inputs();
        repeat (2) @(negedge clk);
        chk(halt == 1'b0,      "R1", "halt after reset",      32'(halt), 0);
        chk(cap_pc == '0,      "R1", "cap_pc after reset",    32'(cap_pc), 0);
        chk(cap_flags == '0,   "R1", "cap_flags after reset", 32'(cap_flags), 0);
        rst_n = 1'b1;
    endtask

    task automatic run(input int tb, input int tf, input int len);
        int d;
        int last;
        logic [PC_W-1:0] exp_pc;
        logic [3:0]      exp_fl;
        do_reset();
        d = decide(tb, tf, len);
        flag_brk_en = (tf >= 0);
        last = (d >= 0) ? d + 1 : BI + len + 6;
        for (int k = 0; k <= last; k++) begin
            @(negedge clk);
            chk(halt == (d >= 0 && k > d), (d == BI + len) ? "R3" : "R2",
                "halt timing", 32'(halt), 32'(d >= 0 && k > d));
            if (d < 0 || k <= d) begin
                insn_boundary = bnd(k, len);
                irq_pending   = irqp(k);
                stack_done    = (k == BI + len);
                brk_req       = (k == tb);
                cpu_flags     = flg(k, len, tf);
                next_pc       = 16'h0100 + 16'(k);
            end else begin
                zero_inputs();
                brk_req = 1'b1;              // R8: ignored while halted
            end
        end
        if (d >= 0) begin
            exp_pc = (d == BI + len) ? VEC : 16'h0100 + 16'(d);
            exp_fl = flg(d, len, tf);
            @(negedge clk);
            chk(cap_pc == exp_pc, (d == BI + len) ? "R4" : "R2", "cap_pc",
                32'(cap_pc), 32'(exp_pc));
            chk(cap_flags == exp_fl, "R5", "cap_flags", 32'(cap_flags), 32'(exp_fl));
            chk(halt == 1'b1, "R7", "halt held", 32'(halt), 1);
            brk_req   = 1'b0;
            cpu_flags = 4'b0100;             // R8: I rise while halted
            resume    = 1'b1;
            @(negedge clk);
            chk(halt == 1'b0,      "R7", "halt after resume", 32'(halt), 0);
            chk(resume_go == 1'b1, "R7", "resume_go pulse",   32'(resume_go), 1);
            chk(cap_pc == exp_pc,  "R7", "restart address",   32'(cap_pc), 32'(exp_pc));
            resume = 1'b0; insn_boundary = 1'b1;
            for (int j = 0; j < 4; j++) begin
                @(negedge clk);
                chk(halt == 1'b0, "R8", "no halt from ignored request", 32'(halt), 0);
                chk(resume_go == 1'b0, "R7", "resume_go single", 32'(resume_go), 0);
                chk(cap_flags == exp_fl, "R8", "flags frozen", 32'(cap_flags), 32'(exp_fl));
            end
        end else begin
            zero_inputs();
            resume = 1'b1;
            @(negedge clk);
            resume = 1'b0;
            @(negedge clk);
            chk(resume_go == 1'b0, "R9", "resume while running", 32'(resume_go), 0);
            chk(halt == 1'b0, "R10", "no halt without break", 32'(halt), 0);
        end
        zero_inputs();
        flag_brk_en = 1'b0;
    endtask

    initial begin
        for (int len = 1; len <= 4; len++)
            for (int tb = 0; tb <= BI + len + 3; tb++)
                run(tb, -1, len);            // R2, R3, R4 sweep
        run(-1, BI, 2);                      // R6 rise on interrupt boundary, R5 shows I=0
        run(-1, 2, 2);                       // R6 rise on a plain boundary
        run(-1, 3, 3);                       // R6 rise between boundaries
        run(-1, -1, 3);                      // R10, R9
        finish_run();
    end

    initial begin
        #750000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end
endmodule